// File: doc/BRIEF.md
# Frame-Sync Polarity Detector and Serial Timing Generator

The block watches a frame-sync line and a serial bit clock and works out, with no configuration, which of two backplane conventions is in use: an active-low frame pulse with falling-edge bit boundaries, or an active-high frame pulse with rising-edge bit boundaries. Both inputs are asynchronous and are oversampled by a faster system clock. Once it has seen two frame pulses of the same polarity one frame apart, it declares lock. It then emits single-cycle strobes for bit boundaries (the transmit-shift point), the three-quarter sample point, and the frame start. It also emits a channel number and a bit index, which the serial ports and the data-memory addressing use.

A frame holds 32 channels of 8 bits, which is 256 bit cells or 512 serial clock periods. Each bit cell spans two serial clock periods, so it spans four serial clock edges. The frame line is sampled on every rising serial clock edge. A pulse is one sample that differs from both its neighbours, so the block confirms a pulse on the rising edge after the sample. If an expected pulse does not arrive, or a pulse arrives at the wrong time or with the wrong polarity, the block drops lock and all strobes stop.

Top module: `fsync_autodet`

## Requirements
- R1: After reset, locked_o and gci_mode_o are 0, all three strobes are 0, chan_o is 0 and bit_idx_o is 7.
- R2: The frame line is sampled on each rising serial clock edge, and a sample that differs from both the previous and the next sample is a pulse. A low pulse marks active-low timing (gci_mode_o = 0). A high pulse marks active-high timing (gci_mode_o = 1 once locked).
- R3: locked_o rises on the rising edge that confirms a second pulse. That pulse must have the same polarity as the first and come exactly 512 serial clock periods after it. A second pulse at any other spacing does not lock; it becomes the new first pulse.
- R4: A candidate or locked state expects a pulse 512 periods after the last one. If no pulse is confirmed at that edge, locked_o falls, gci_mode_o clears and the candidate is dropped. While unlocked, gci_mode_o is 0.
- R5: While locked, a pulse confirmed at an unexpected edge or with the other polarity drops lock and becomes the new candidate.
- R6: While unlocked, bit_start_o, sample_o and frame_start_o stay 0, chan_o reads 0 and bit_idx_o reads 7.
- R7: Active-low timing: the frame boundary is the falling edge right after the rising edge that sampled the pulse. bit_start_o fires on every second falling edge from that boundary. sample_o fires on the rising edge three quarters of the way into each cell.
- R8: Active-high timing: the frame boundary is the rising edge that confirms the pulse. bit_start_o fires on every second rising edge from that boundary. sample_o fires on the falling edge three quarters of the way into each cell.
- R9: bit_idx_o counts 7 down to 0 (MSB first) and steps at each bit_start_o. chan_o advances when bit_idx_o wraps from 0 to 7, covering channels 0 to 31. frame_start_o fires together with bit_start_o at channel 0, bit 7, once every 256 cells. Both counters hold steady at a sample_o.
- R10: Each strobe is one system clock cycle wide per qualifying serial clock edge. It appears three system clock edges after the serial clock edge: two synchronizer stages and one edge-detect stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial bit clock (two periods per bit cell) |
| fsync_i | input | 1 | Frame-sync line of unknown polarity |
| locked_o | output | 1 | Frame timing is locked |
| gci_mode_o | output | 1 | 1 = active-high convention detected (valid while locked) |
| bit_start_o | output | 1 | Bit-boundary / transmit-shift strobe |
| sample_o | output | 1 | Three-quarter-cell sample strobe |
| frame_start_o | output | 1 | Frame-boundary strobe |
| chan_o | output | 5 | Current channel number |
| bit_idx_o | output | 3 | Current bit index, 7 first |

## Verification
The hardest states to reach are those where lock is lost or must not be gained. These are a missing pulse after lock, a pulse one or two periods early or late, and an idle level that flips so that the next pulse has the other polarity while the block is locked. Each scenario builds its frame line from a pulse schedule with optional faults: a skipped pulse, a shifted pulse, or a polarity flip. Directed scenarios place each fault on purpose. Seeded random scenarios pick the polarity, the start offset and the faults. A bench model replays every serial clock edge and predicts lock, type, counters and strobe counts for each half period.

// File: rtl/fsd_pkg.sv
`timescale 1ns/1ps
package fsd_pkg;
  typedef enum logic {
    FS_ACT_LOW  = 1'b0,
    FS_ACT_HIGH = 1'b1
  } fs_pol_e;

  localparam int unsigned EDGES_PER_CELL = 4;
  localparam int unsigned SAMPLE_PHASE   = 3;
endpackage

// File: rtl/fsd_sync.sv
`timescale 1ns/1ps
module fsd_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/fsd_edge.sv
`timescale 1ns/1ps
module fsd_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/fsd_lock.sv
`timescale 1ns/1ps
module fsd_lock
  import fsd_pkg::*;
#(
  parameter int unsigned PERIODS = 512
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    rise_i,
  input  logic    fs_i,
  output logic    lock_o,
  output logic    lock_nxt_o,
  output logic    accept_o,
  output fs_pol_e pol_o,
  output fs_pol_e type_o
);
  localparam int unsigned RW = $clog2(PERIODS);

  logic [1:0]    hist_q;
  logic          cand_q, cand_n;
  logic          lock_q, lock_n;
  fs_pol_e       cpol_q, cpol_n;
  fs_pol_e       type_q, type_n;
  logic [RW-1:0] rcnt_q, rcnt_n;
  logic          pulse, due;

  // isolated sample: newest history bit differs from both neighbours
  assign pulse = (hist_q[0] != hist_q[1]) && (hist_q[0] != fs_i);
  assign due   = (cand_q | lock_q) && (rcnt_q == RW'(PERIODS-1));
  assign pol_o = fs_pol_e'(hist_q[0]);

  always_comb begin
    cand_n   = cand_q;
    lock_n   = lock_q;
    cpol_n   = cpol_q;
    type_n   = type_q;
    rcnt_n   = rcnt_q;
    accept_o = 1'b0;
    if (rise_i) begin
      rcnt_n = (rcnt_q == RW'(PERIODS-1)) ? '0 : rcnt_q + 1'b1;
      if (pulse) begin
        rcnt_n = '0;
        cand_n = 1'b1;
        if (due && (pol_o == cpol_q)) begin
          lock_n   = 1'b1;
          type_n   = pol_o;
          accept_o = 1'b1;
        end else begin
          lock_n = 1'b0;
          type_n = FS_ACT_LOW;
          cpol_n = pol_o;
        end
      end else if (due) begin
        lock_n = 1'b0;
        type_n = FS_ACT_LOW;
        cand_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      cand_q <= 1'b0;
      lock_q <= 1'b0;
      cpol_q <= FS_ACT_LOW;
      type_q <= FS_ACT_LOW;
      rcnt_q <= '0;
    end else begin
      if (rise_i) hist_q <= {hist_q[0], fs_i};
      cand_q <= cand_n;
      lock_q <= lock_n;
      cpol_q <= cpol_n;
      type_q <= type_n;
      rcnt_q <= rcnt_n;
    end
  end

  assign lock_o     = lock_q;
  assign lock_nxt_o = lock_n;
  assign type_o     = type_q;
endmodule

// File: rtl/fsd_timing.sv
`timescale 1ns/1ps
module fsd_timing
  import fsd_pkg::*;
#(
  parameter int unsigned CHANNELS    = 32,
  parameter int unsigned BITS_PER_CH = 8,
  localparam int unsigned CW = $clog2(CHANNELS),
  localparam int unsigned BW = $clog2(BITS_PER_CH),
  localparam int unsigned EW = CW + BW + $clog2(EDGES_PER_CELL)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          edge_i,
  input  logic          accept_i,
  input  logic [EW-1:0] load_i,
  input  logic          lock_i,
  input  logic          lock_nxt_i,
  output logic          bit_start_o,
  output logic          sample_o,
  output logic          frame_start_o,
  output logic [CW-1:0] chan_o,
  output logic [BW-1:0] bit_idx_o
);
  localparam int unsigned PW = $clog2(EDGES_PER_CELL);

  logic [EW-1:0] e_q;
  logic          edge_q;
  logic          act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_q    <= '0;
      edge_q <= 1'b0;
    end else begin
      edge_q <= edge_i;
      if (accept_i)        e_q <= load_i;
      else if (!lock_nxt_i) e_q <= '0;
      else if (edge_i)     e_q <= e_q + 1'b1;
    end
  end

  assign act           = lock_i & edge_q;
  assign bit_start_o   = act && (e_q[PW-1:0] == '0);
  assign sample_o      = act && (e_q[PW-1:0] == PW'(SAMPLE_PHASE));
  assign frame_start_o = act && (e_q == '0);
  assign chan_o        = e_q[EW-1 -: CW];
  assign bit_idx_o     = BW'(BITS_PER_CH-1) - e_q[PW +: BW];
endmodule

// File: rtl/fsync_autodet.sv
`timescale 1ns/1ps
module fsync_autodet
  import fsd_pkg::*;
#(
  parameter int unsigned CHANNELS    = 32,
  parameter int unsigned BITS_PER_CH = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CW = $clog2(CHANNELS),
  localparam int unsigned BW = $clog2(BITS_PER_CH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_i,
  input  logic          fsync_i,
  output logic          locked_o,
  output logic          gci_mode_o,
  output logic          bit_start_o,
  output logic          sample_o,
  output logic          frame_start_o,
  output logic [CW-1:0] chan_o,
  output logic [BW-1:0] bit_idx_o
);
  localparam int unsigned PERIODS = CHANNELS * BITS_PER_CH * EDGES_PER_CELL / 2;
  localparam int unsigned EW      = CW + BW + $clog2(EDGES_PER_CELL);

  logic [1:0]    syn;
  logic          rise, fall;
  logic          lock, lock_nxt, accept;
  fs_pol_e       pol, bp_type;
  logic [EW-1:0] load;

  fsd_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, fsync_i}),
    .q_o   (syn)
  );

  fsd_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (syn[1]),
    .rise_o(rise),
    .fall_o(fall)
  );

  fsd_lock #(.PERIODS(PERIODS)) u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise),
    .fs_i      (syn[0]),
    .lock_o    (lock),
    .lock_nxt_o(lock_nxt),
    .accept_o  (accept),
    .pol_o     (pol),
    .type_o    (bp_type)
  );

  // active-low: confirming rise is one edge past the boundary; active-high: it is the boundary
  assign load = (pol == FS_ACT_HIGH) ? '0 : EW'(1);

  fsd_timing #(.CHANNELS(CHANNELS), .BITS_PER_CH(BITS_PER_CH)) u_timing (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .edge_i       (rise | fall),
    .accept_i     (accept),
    .load_i       (load),
    .lock_i       (lock),
    .lock_nxt_i   (lock_nxt),
    .bit_start_o  (bit_start_o),
    .sample_o     (sample_o),
    .frame_start_o(frame_start_o),
    .chan_o       (chan_o),
    .bit_idx_o    (bit_idx_o)
  );

  assign locked_o   = lock;
  assign gci_mode_o = (bp_type == FS_ACT_HIGH);
endmodule

// File: rtl/fsd_checker.sv
`timescale 1ns/1ps
module fsd_checker #(
  parameter int unsigned CW = 5,
  parameter int unsigned BW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          locked_o,
  input logic          gci_mode_o,
  input logic          bit_start_o,
  input logic          sample_o,
  input logic          frame_start_o,
  input logic [CW-1:0] chan_o,
  input logic [BW-1:0] bit_idx_o
);
  localparam logic [BW-1:0] TOP = '1;

  AST_STROBE_NEEDS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_start_o | sample_o | frame_start_o) |-> locked_o); // R6
  AST_IDLE_COUNTERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_o |-> (chan_o == '0) && (bit_idx_o == TOP)); // R6
  AST_TYPE_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_o |-> !gci_mode_o); // R4
  AST_FRAME_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> bit_start_o && (chan_o == '0) && (bit_idx_o == TOP)); // R9
  AST_BIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_start_o && $past(locked_o)) |-> (bit_idx_o == $past(bit_idx_o) - 1'b1)); // R9
  AST_SAMPLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> $stable(chan_o) && $stable(bit_idx_o)); // R9
  AST_BIT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_start_o |=> !bit_start_o); // R10
  AST_SAMPLE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o); // R10
  AST_PHASE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bit_start_o && sample_o)); // R7
endmodule

bind fsync_autodet fsd_checker #(.CW(CW), .BW(BW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .locked_o     (locked_o),
  .gci_mode_o   (gci_mode_o),
  .bit_start_o  (bit_start_o),
  .sample_o     (sample_o),
  .frame_start_o(frame_start_o),
  .chan_o       (chan_o),
  .bit_idx_o    (bit_idx_o)
);

// File: tb/sim_fsync_autodet.sv
`timescale 1ns/1ps
module sim_fsync_autodet;
  localparam int HALF = 4;
  localparam int PER  = 512;
  localparam int EDG  = 1024;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sclk = 1'b0;
  logic       fsync = 1'b1;
  logic       locked, gci, bs, smp, fst;
  logic [4:0] chan;
  logic [2:0] bidx;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  // reference model state
  bit m_h0, m_h1, m_cand, m_cpol, m_lock, m_type;
  int m_rcnt, m_e;

  always #2.5 clk = ~clk;

  fsync_autodet u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .fsync_i(fsync),
    .locked_o(locked), .gci_mode_o(gci), .bit_start_o(bs), .sample_o(smp),
    .frame_start_o(fst), .chan_o(chan), .bit_idx_o(bidx)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_h0 = 0; m_h1 = 0; m_cand = 0; m_cpol = 0; m_lock = 0; m_type = 0;
    m_rcnt = 0; m_e = 0;
  endtask

  task automatic model_edge(input bit rising, input bit fs);
    bit pd, due;
    if (rising) begin
      pd  = (m_h0 != m_h1) && (m_h0 != fs);
      due = (m_cand || m_lock) && (m_rcnt == PER-1);
      if (pd) begin
        m_rcnt = 0;
        m_cand = 1;
        if (due && m_h0 == m_cpol) begin
          m_lock = 1; m_type = m_h0; m_e = m_h0 ? 0 : 1;
        end else begin
          m_lock = 0; m_type = 0; m_cpol = m_h0; m_e = 0;
        end
      end else if (due) begin
        m_lock = 0; m_type = 0; m_cand = 0; m_e = 0; m_rcnt = 0;
      end else begin
        m_rcnt = (m_rcnt + 1) % PER;
        if (m_lock) m_e = (m_e + 1) % EDG;
      end
      m_h1 = m_h0; m_h0 = fs;
    end else if (m_lock) begin
      m_e = (m_e + 1) % EDG;
    end
  endtask

  task automatic half(input bit lvl, input bit fs);
    int cb, cs, cf, eb, es, ef, ec, ei;
    string st;
    sclk = lvl;
    fsync = fs;
    cb = 0; cs = 0; cf = 0;
    repeat (HALF) begin
      @(negedge clk);
      cb += int'(bs); cs += int'(smp); cf += int'(fst);
    end
    model_edge(lvl, fs);
    eb = (m_lock && m_e % 4 == 0) ? 1 : 0;
    es = (m_lock && m_e % 4 == 3) ? 1 : 0;
    ef = (m_lock && m_e == 0) ? 1 : 0;
    ec = m_lock ? (m_e >> 5) : 0;
    ei = m_lock ? 7 - ((m_e >> 2) & 7) : 7;
    st = !m_lock ? "R6" : (m_type ? "R8" : "R7");
    chk(int'(locked) == int'(m_lock), m_lock ? "R3" : "R4", "locked", int'(locked), int'(m_lock));
    chk(int'(gci) == int'(m_lock & m_type), "R2", "gci_mode", int'(gci), int'(m_lock & m_type));
    chk(cb == eb, cb > 1 ? "R10" : st, "bit_start count", cb, eb);
    chk(cs == es, cs > 1 ? "R10" : st, "sample count", cs, es);
    chk(cf == ef, "R9", "frame_start count", cf, ef);
    chk(int'(chan) == ec, "R9", "chan", int'(chan), ec);
    chk(int'(bidx) == ei, "R9", "bit_idx", int'(bidx), ei);
  endtask

  // pulse schedule: k-th pulse at off+512k (+shift from shift_idx on), skipped at miss_idx,
  // idle level inverts three periods before pulse flip_idx
  task automatic run(input bit pol_high, input int off, input int np, input int miss_idx,
                     input int shift_idx, input int shift, input int flip_idx, input bit chk_reset);
    int last;
    bit idle_lvl;
    idle_lvl = pol_high ? 1'b0 : 1'b1;
    rst_ni = 1'b0; sclk = 1'b0; fsync = idle_lvl;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    model_reset();
    repeat (3) @(negedge clk);
    if (chk_reset) begin
      // R1 reset state
      chk(locked == 1'b0, "R1", "locked", int'(locked), 0);
      chk(gci == 1'b0, "R1", "gci_mode", int'(gci), 0);
      chk({bs, smp, fst} == 3'b000, "R1", "strobes", int'({bs, smp, fst}), 0);
      chk(chan == 5'd0, "R1", "chan", int'(chan), 0);
      chk(bidx == 3'd7, "R1", "bit_idx", int'(bidx), 7);
    end
    half(1'b1, idle_lvl);
    last = off + PER * (np - 1) + (shift > 0 ? shift : 0) + 6;
    for (int p = 0; p <= last; p++) begin
      bit cur_high, act;
      cur_high = pol_high ^ ((flip_idx >= 0) && (p >= off + PER * flip_idx - 3));
      act = 1'b0;
      for (int k = 0; k < np; k++) begin
        int pos;
        pos = off + PER * k + ((shift_idx >= 0 && k >= shift_idx) ? shift : 0);
        if (p == pos && k != miss_idx) act = 1'b1;
      end
      half(1'b0, (cur_high ? 1'b0 : 1'b1) ^ act);
      half(1'b1, fsync);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4177);
    // R7 clean active-low frames, lock on second pulse (R3)
    run(1'b0, 6, 4, -1, -1, 0, -1, 1'b1);
    chk(locked && !gci, "R7", "active-low lock held", int'(locked), 1);
    // R8 clean active-high frames
    run(1'b1, 9, 4, -1, -1, 0, -1, 1'b0);
    chk(locked && gci, "R2", "active-high type", int'(gci), 1);
    // R4 missing pulse after lock, relock later
    run(1'b0, 5, 5, 2, -1, 0, -1, 1'b0);
    // R3 late second pulse must not lock, next on-time pulse does
    run(1'b1, 7, 4, -1, 1, 1, -1, 1'b0);
    // R5 polarity flips while locked
    run(1'b0, 8, 5, -1, -1, 0, 2, 1'b0);
    chk(locked && gci, "R5", "relock on new polarity", int'(gci), 1);
    // seeded random scenarios
    for (int r = 0; r < 3; r++) begin
      bit ph;
      int off, miss, sidx, sh;
      ph   = 1'($urandom_range(0, 1));
      off  = int'($urandom_range(4, 40));
      miss = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 2)) : -1;
      sidx = ($urandom_range(0, 2) == 0) ? int'($urandom_range(1, 2)) : -1;
      sh   = ($urandom_range(0, 1) == 0) ? -int'($urandom_range(1, 2)) : int'($urandom_range(1, 2));
      run(ph, off, 3, miss, sidx, sh, -1, 1'b0);
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule